// File: doc/BRIEF.md
# Keyboard Matrix Scanner with Key FIFO

This block walks a matrix of up to 64 switches, eight drive rows by eight sense columns, one row per scan step. The step rate comes from a programmable divider of the input clock. A switch that stays closed on two back-to-back visits of its row becomes a key event. The event's code, tagged with the current levels of the shift and control inputs, is pushed into an eight-entry queue. The host pops the queue through a simple read strobe, sees an interrupt level whenever entries are waiting, and gets a sticky overrun flag if a key arrives while the queue is full. A clear strobe empties the queue and drops both flags.

The row drive can be a one-hot active-low pattern that drives the matrix directly, or a binary row number for an external decoder. Acceptance follows either two-key lockout or N-key rollover. A third setting turns the queue storage into an eight-byte sensor image: on every step, the byte for the current row is overwritten with that row's closure pattern, and the host reads any row by address.

Top module: `kbd_scan_top`

## Requirements
- R1: After reset, the queue is empty (`fifo_count`=0), `irq`=0, `overrun`=0, and row 0 is selected: `scan_out`=8'hFE in one-hot mode, 8'h00 in binary mode.
- R2: The selected row advances by one, wrapping 7 to 0, once every `scan_div`+1 clocks. The first step falls `scan_div`+1 clocks after reset.
- R3: With `decoded_sel`=1, `scan_out` is all ones except a single 0 at the bit of the selected row. With `decoded_sel`=0, `scan_out[2:0]` holds the row number and the upper bits are 0.
- R4: A sense column reading low while a row is selected means that switch is closed. A switch is queued at the step where it is seen closed for the second consecutive visit of its row. A switch seen closed on only one visit is never queued. A queued switch is queued again only after it has been seen open and then closed twice more.
- R5: A queued byte is control(bit 7), shift(bit 6), row(bits 5:3), column(bits 2:0). Shift and control are the input levels at the step where the byte is queued.
- R6: With `rollover_sel`=1, every qualifying switch is queued. If several in one row qualify at the same step, only the lowest column is queued at that step, and the others are queued on later visits of that row.
- R7: With `rollover_sel`=0, no switch is queued while any previously queued switch is still held closed. A switch pressed during that time is queued once the held one is seen open and the waiting switch qualifies on a later visit.
- R8: The queue is first-in first-out. `rd_data` shows the oldest entry while `fifo_count`>0. A one-cycle `rd_en` removes that entry. `fifo_count` never exceeds 8.
- R9: A key event arriving while 8 entries are stored is discarded and sets `overrun`, which stays set until clear or reset. A read in the same cycle does not make room for it.
- R10: `irq` is 1 exactly when `fifo_count` is nonzero.
- R11: A one-cycle `clr` empties the queue and clears `overrun` and `irq` from the next cycle. In sensor mode it also zeroes all eight sensor bytes.
- R12: With `sensor_sel`=1, nothing is queued. At each step, sensor byte [row] is loaded with the row's closure pattern (bit c = 1 when column c is closed). `rd_data` shows byte [`sense_addr`], and `fifo_count` and `irq` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_div | input | 8 | Clocks per scan step minus one |
| decoded_sel | input | 1 | 1: one-hot active-low row drive, 0: binary row number |
| rollover_sel | input | 1 | 1: N-key rollover, 0: two-key lockout |
| sensor_sel | input | 1 | 1: sensor image mode instead of key events |
| ret_n | input | 8 | Sense columns, low when closed (pulled up outside) |
| shift_in | input | 1 | Shift level stored with each key byte |
| ctrl_in | input | 1 | Control level stored with each key byte |
| rd_en | input | 1 | Pop the oldest queue entry |
| clr | input | 1 | Empty queue, clear overrun and sensor image |
| sense_addr | input | 3 | Sensor byte to show on rd_data in sensor mode |
| scan_out | output | 8 | Row drive, one-hot low or binary |
| rd_data | output | 8 | Oldest queue entry, or addressed sensor byte |
| fifo_count | output | 4 | Number of queued entries |
| irq | output | 1 | Entries waiting |
| overrun | output | 1 | Sticky lost-key flag |

## Verification
The checks take for granted that the three mode selects and `scan_div` stay constant between resets. They also assume that `ret_n` is a settled function of the row currently driven, so each step samples the selected row and no other. The bench applies every mode change through a reset. It derives `ret_n` combinationally from its own key map and the decoded `scan_out`, and changes keys, shift, control and strobes only on falling edges, one clock wide for `rd_en` and `clr`.

// File: rtl/kbd_pkg.sv
// Package: shared sizes and the layout of a queued key byte.
// Assumes the matrix is square in powers of two (rows and columns of 2**3).
package kbd_pkg;
    localparam int KB_ROW_W = 3;
    localparam int KB_COL_W = 3;

    typedef struct packed {
        logic                ctrl;
        logic                shift;
        logic [KB_ROW_W-1:0] row;
        logic [KB_COL_W-1:0] col;
    } key_byte_t;
endpackage

// File: rtl/kbd_prescaler.sv
// Clock divider: emits one-cycle step pulses, one every div+1 clocks.
// Assumes div is held constant outside reset.
module kbd_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == div);

    // Count clocks, restarting at each step pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/kbd_scan_ctr.sv
// Row sequencer: holds the selected row and forms the row drive pattern.
// Assumes the format select is static; the drive is a registered row decoded.
module kbd_scan_ctr #(
    parameter int ROW_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    decoded,
    output logic [ROW_W-1:0]        row,
    output logic [(1<<ROW_W)-1:0]   scan_out
);
    localparam int ROWS = 1 << ROW_W;
    localparam logic [ROW_W-1:0] ROW_ONE = 1;

    // Step to the next row on each pulse, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)    row <= '0;
        else if (tick) row <= row + ROW_ONE;
    end

    // Drive either one active-low line or the binary row number.
    always_comb begin
        if (decoded) scan_out = ~(ROWS'(1) << row);
        else         scan_out = ROWS'(row);
    end

    // R2
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (row == $past(row) + ROW_ONE));
    // R2
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(row));
endmodule

// File: rtl/kbd_debounce.sv
// Closure qualifier: keeps last-visit and accepted maps for every switch and
// picks at most one new key per step (lowest column of the visited row).
// Assumes ret_n reflects the currently driven row when tick is high.
module kbd_debounce #(
    parameter int ROW_W = 3,
    parameter int COL_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [ROW_W-1:0]      row,
    input  logic [(1<<COL_W)-1:0] ret_n,
    input  logic                  rollover,
    input  logic                  enable,
    output logic                  ev_valid,
    output logic [COL_W-1:0]      ev_col,
    output logic [(1<<COL_W)-1:0] closed
);
    localparam int ROWS = 1 << ROW_W;
    localparam int COLS = 1 << COL_W;

    logic [ROWS-1:0][COLS-1:0] seen_q;
    logic [ROWS-1:0][COLS-1:0] held_q;
    logic [COLS-1:0]           qual;
    logic [COLS-1:0]           ev_mask;

    assign closed = ~ret_n;

    // Find switches closed now and on the last visit, not yet accepted.
    always_comb begin
        qual = closed & seen_q[row] & ~held_q[row];
        if (!rollover && (|held_q)) qual = '0;
        if (!enable || !tick)       qual = '0;
        ev_valid = |qual;
        ev_col   = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (qual[c]) ev_col = COL_W'(c);
        end
        ev_mask = ev_valid ? (COLS'(1) << ev_col) : '0;
    end

    // Record this visit and update the accepted map for the row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
            held_q <= '0;
        end else if (tick) begin
            seen_q[row] <= closed;
            held_q[row] <= (held_q[row] & closed) | ev_mask;
        end
    end

    // R7
    lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !rollover) |=> $countones(held_q) == 1);
endmodule

// File: rtl/kbd_store.sv
// Key queue / sensor image: a first-in first-out queue of key bytes in key
// mode, a row-addressed byte array in sensor mode. Assumes DEPTH is a power
// of two not smaller than the row count; clear has priority over writes.
module kbd_store #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    parameter int ROW_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       sensor,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    input  logic                       sense_wr,
    input  logic [ROW_W-1:0]           sense_row,
    input  logic [W-1:0]               sense_data,
    input  logic [$clog2(DEPTH)-1:0]   sense_addr,
    output logic [W-1:0]               rd_data,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       ovr
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = AW + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DEPTH-1:0][W-1:0] mem_q;
    logic [AW-1:0]           wp_q, rp_q;
    logic                    full, wr_ok, rd_ok;

    assign full  = (count == FULL_CNT);
    assign wr_ok = push && !full && !sensor;
    assign rd_ok = pop && (count != '0) && !sensor;
    assign rd_data = sensor ? mem_q[sense_addr] : mem_q[rp_q];

    // Move pointers and occupancy; latch a lost key as overrun.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            count <= '0;
            ovr   <= 1'b0;
        end else begin
            if (wr_ok) wp_q <= wp_q + 1'b1;
            if (rd_ok) rp_q <= rp_q + 1'b1;
            count <= count + CNT_W'(wr_ok) - CNT_W'(rd_ok);
            if (push && full && !sensor) ovr <= 1'b1;
        end
    end

    // Write a key byte at the tail, or a row image at its row slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mem_q <= '0;
        end else if (sensor) begin
            if (sense_wr) mem_q[AW'(sense_row)] <= sense_data;
        end else if (wr_ok) begin
            mem_q[wp_q] <= push_data;
        end
    end

    // R8
    depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    // R9
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !sensor && !clr) |=> ovr);
    // R11
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0) && !ovr);
endmodule

// File: rtl/kbd_scan_top.sv
// Keyboard matrix scanner top: divider, row sequencer, closure qualifier
// and queue. Assumes mode selects and scan_div change only under reset and
// that ret_n settles to the driven row within one step.
module kbd_scan_top
    import kbd_pkg::*;
#(
    parameter int ROW_W = KB_ROW_W,
    parameter int COL_W = KB_COL_W,
    parameter int DEPTH = 8,
    parameter int DIV_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DIV_W-1:0]          scan_div,
    input  logic                      decoded_sel,
    input  logic                      rollover_sel,
    input  logic                      sensor_sel,
    input  logic [(1<<COL_W)-1:0]     ret_n,
    input  logic                      shift_in,
    input  logic                      ctrl_in,
    input  logic                      rd_en,
    input  logic                      clr,
    input  logic [$clog2(DEPTH)-1:0]  sense_addr,
    output logic [(1<<ROW_W)-1:0]     scan_out,
    output logic [2+ROW_W+COL_W-1:0]  rd_data,
    output logic [$clog2(DEPTH):0]    fifo_count,
    output logic                      irq,
    output logic                      overrun
);
    localparam int COLS   = 1 << COL_W;
    localparam int CODE_W = 2 + ROW_W + COL_W;

    logic               tick, ev_valid, push;
    logic [ROW_W-1:0]   row;
    logic [COL_W-1:0]   ev_col;
    logic [COLS-1:0]    closed;
    logic [CODE_W-1:0]  code;

    kbd_prescaler #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div(scan_div), .tick(tick));

    kbd_scan_ctr #(.ROW_W(ROW_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .tick(tick), .decoded(decoded_sel),
        .row(row), .scan_out(scan_out));

    kbd_debounce #(.ROW_W(ROW_W), .COL_W(COL_W)) u_deb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .row(row), .ret_n(ret_n),
        .rollover(rollover_sel), .enable(!sensor_sel),
        .ev_valid(ev_valid), .ev_col(ev_col), .closed(closed));

    // Assemble the key byte: control, shift, row, column.
    assign code = {ctrl_in, shift_in, row, ev_col};
    assign push = ev_valid;

    kbd_store #(.DEPTH(DEPTH), .W(CODE_W), .ROW_W(ROW_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .sensor(sensor_sel),
        .push(push), .push_data(code), .pop(rd_en),
        .sense_wr(tick), .sense_row(row), .sense_data(CODE_W'(closed)),
        .sense_addr(sense_addr), .rd_data(rd_data), .count(fifo_count),
        .ovr(overrun));

    assign irq = (fifo_count != '0);

    // R3
    onehot_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decoded_sel |-> $onehot(~scan_out));
    // R10
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr && !sensor_sel) |=> irq);
    // R12
    sensor_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sensor_sel |=> !irq);
endmodule

// File: tb/kbd_scan_top_bench.sv
// Bench: behavioural key-map model with a queue, compared on every clock,
// plus directed checks with hand-computed values.
module kbd_scan_top_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] scan_div = 8'd1;
    logic       decoded_sel = 1, rollover_sel = 1, sensor_sel = 0;
    logic [7:0] ret_n;
    logic       shift_in = 0, ctrl_in = 0, rd_en = 0, clr = 0;
    logic [2:0] sense_addr = 0;
    logic [7:0] scan_out, rd_data;
    logic [3:0] fifo_count;
    logic       irq, overrun;

    int total = 0, bad = 0;
    bit keys[64];
    bit done = 0;

    kbd_scan_top u_kbd_scan_top (
        .clk(clk), .rst_n(rst_n), .scan_div(scan_div),
        .decoded_sel(decoded_sel), .rollover_sel(rollover_sel),
        .sensor_sel(sensor_sel), .ret_n(ret_n), .shift_in(shift_in),
        .ctrl_in(ctrl_in), .rd_en(rd_en), .clr(clr), .sense_addr(sense_addr),
        .scan_out(scan_out), .rd_data(rd_data), .fifo_count(fifo_count),
        .irq(irq), .overrun(overrun));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Matrix model: sense lines follow the row the block is driving.
    always_comb begin
        int r;
        r = 0;
        if (decoded_sel) begin
            for (int i = 0; i < 8; i++) if (!scan_out[i]) r = i;
        end else r = int'(scan_out[2:0]);
        for (int c = 0; c < 8; c++) ret_n[c] = ~keys[r*8 + c];
    end

    // Reference state.
    int m_cnt, m_row;
    bit m_seen[64], m_held[64];
    logic [7:0] m_q[$];
    bit m_ovr;
    logic [7:0] m_sens[8];
    bit m_live = 0;

    // Behavioural model advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_row = 0; m_ovr = 0; m_q.delete();
            for (int i = 0; i < 64; i++) begin m_seen[i] = 0; m_held[i] = 0; end
            for (int i = 0; i < 8; i++) m_sens[i] = 0;
            m_live = 1;
        end else begin
            bit tk, any, full;
            int ev;
            logic [7:0] img;
            tk = (m_cnt == int'(scan_div));
            ev = -1;
            img = 0;
            if (tk) begin
                any = 0;
                for (int i = 0; i < 64; i++) any |= m_held[i];
                for (int c = 0; c < 8; c++) img[c] = keys[m_row*8 + c];
                if (!sensor_sel) begin
                    for (int c = 0; c < 8; c++) begin
                        if (ev < 0 && keys[m_row*8+c] && m_seen[m_row*8+c] &&
                            !m_held[m_row*8+c] && (rollover_sel || !any)) ev = c;
                    end
                end
                for (int c = 0; c < 8; c++) begin
                    m_held[m_row*8+c] = (m_held[m_row*8+c] && keys[m_row*8+c]) || (ev == c);
                    m_seen[m_row*8+c] = keys[m_row*8+c];
                end
            end
            if (clr) begin
                m_q.delete(); m_ovr = 0;
                for (int i = 0; i < 8; i++) m_sens[i] = 0;
            end else if (sensor_sel) begin
                if (tk) m_sens[m_row] = img;
            end else begin
                full = (m_q.size() >= 8);
                if (rd_en && m_q.size() > 0) void'(m_q.pop_front());
                if (ev >= 0) begin
                    if (full) m_ovr = 1;
                    else m_q.push_back({ctrl_in, shift_in, 3'(m_row), 3'(ev)});
                end
            end
            if (tk) begin m_cnt = 0; m_row = (m_row + 1) % 8; end
            else m_cnt = m_cnt + 1;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (m_live && rst_n && !done) begin
            logic [7:0] es;
            es = decoded_sel ? ~(8'd1 << m_row) : 8'(m_row);
            check("R2/R3 scan_out", scan_out, es);
            check("R8 fifo_count", fifo_count, m_q.size());
            check("R10 irq", irq, m_q.size() > 0);
            check("R9 overrun", overrun, m_ovr);
            if (sensor_sel) check("R12 sensor byte", rd_data, m_sens[sense_addr]);
            else if (m_q.size() > 0) check("R5/R8 head", rd_data, m_q[0]);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(bit dec, bit roll, bit sens, logic [7:0] dv);
        rst_n = 0;
        for (int i = 0; i < 64; i++) keys[i] = 0;
        decoded_sel = dec; rollover_sel = roll; sensor_sel = sens; scan_div = dv;
        shift_in = 0; ctrl_in = 0; rd_en = 0; clr = 0;
        cyc(3);
        rst_n = 1;
    endtask

    task automatic pop1();
        rd_en = 1; cyc(1); rd_en = 0;
    endtask

    task automatic key(int r, int c, bit v);
        keys[r*8 + c] = v;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset(1, 1, 0, 8'd1);
        cyc(1);
        // R1 reset state
        check("R1 scan_out", scan_out, 8'hFE);
        check("R1 count", fifo_count, 0);
        check("R1 irq", irq, 0);
        check("R1 overrun", overrun, 0);

        // R4 R5: single key with shift held
        shift_in = 1; key(2, 5, 1);
        cyc(60);
        check("R4 queued once", fifo_count, 1);
        check("R5 code", rd_data, 8'h55);
        check("R10 irq set", irq, 1);
        key(2, 5, 0); shift_in = 0;
        cyc(40);
        check("R4 no repeat", fifo_count, 1);
        pop1();
        check("R8 popped", fifo_count, 0);
        check("R10 irq clear", irq, 0);

        // R4: a closure seen on only one visit
        key(4, 1, 1); cyc(10); key(4, 1, 0);
        cyc(60);
        check("R4 short press", fifo_count, 0);

        // R6: rollover, two in one row plus another row, control held
        ctrl_in = 1;
        key(1, 0, 1); key(1, 3, 1); key(6, 7, 1);
        cyc(100);
        check("R6 all queued", fifo_count, 3);
        key(1, 0, 0); key(1, 3, 0); key(6, 7, 0); ctrl_in = 0;
        cyc(40);
        pop1(); pop1(); pop1();
        check("R8 drained", fifo_count, 0);

        // R7: lockout
        do_reset(1, 0, 0, 8'd1);
        key(3, 3, 1); cyc(60);
        check("R7 first", fifo_count, 1);
        key(5, 2, 1); cyc(60);
        check("R7 second ignored", fifo_count, 1);
        key(3, 3, 0); cyc(60);
        check("R7 after release", fifo_count, 2);
        pop1();
        check("R7 code", rd_data, 8'h2A);
        key(5, 2, 0); cyc(40);
        pop1();

        // R9 R11: overrun with nine keys, then clear
        for (int k = 0; k < 9; k++) begin
            key(k % 8, (k * 3) % 8, 1); cyc(60);
            key(k % 8, (k * 3) % 8, 0); cyc(30);
        end
        check("R9 count full", fifo_count, 8);
        check("R9 overrun", overrun, 1);
        check("R8 oldest", rd_data, 8'h00);
        pop1();
        check("R9 sticky", overrun, 1);
        clr = 1; cyc(1); clr = 0;
        check("R11 count", fifo_count, 0);
        check("R11 overrun", overrun, 0);
        check("R11 irq", irq, 0);

        // R3 R2: binary drive, slower divider
        do_reset(0, 1, 0, 8'd3);
        cyc(1);
        check("R1 binary reset", scan_out, 8'h00);
        cyc(4);
        check("R2 step", scan_out, 8'h01);
        key(7, 6, 1); cyc(120);
        check("R5 binary code", rd_data, 8'h3E);
        key(7, 6, 0); cyc(40);
        pop1();

        // R12: sensor image
        do_reset(1, 1, 1, 8'd1);
        key(3, 0, 1); key(3, 7, 1); key(0, 2, 1);
        cyc(40);
        sense_addr = 3; cyc(1);
        check("R12 row3", rd_data, 8'h81);
        sense_addr = 0; cyc(1);
        check("R12 row0", rd_data, 8'h04);
        check("R12 no queue", fifo_count, 0);
        check("R12 no irq", irq, 0);
        key(3, 0, 0); key(3, 7, 0); cyc(40);
        sense_addr = 3; cyc(1);
        check("R12 released", rd_data, 8'h00);
        key(0, 2, 0); cyc(2);
        clr = 1; cyc(1); clr = 0;
        sense_addr = 0;
        check("R11 sensor cleared", rd_data, 8'h00);
        cyc(5);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule